// File: doc/BRIEF.md
# Double-Buffered PWM Generator Channel

This block is a single pulse-width generator that drives a pair of opposing output pins. Software programs a prescaler code, a counter modulus and one pulse-width value per pin into staging registers through a simple register port. None of these staged values reach the running waveform directly. They are copied into an active set only at a reload. A reload is the moment the prescaled counter reaches the active modulus and wraps to zero. The copy happens only when software has armed a load-okay bit, and that bit clears itself once the copy is done.

A write-gate input guards the control bits: the generator enable, the load-okay bit and the reload interrupt enable. While the gate is low these bits read as zero, writes to them are dropped, and they act as zero. Each pin has an override that forces a chosen level. Each reload raises a sticky reload flag, and the flag asserts the interrupt request when the interrupt enable is set.

Register map (3-bit address): 0 control (bit0 enable, bit1 load-okay, bit2 reload interrupt enable), 1 status (bit0 reload flag, write 1 to clear), 2 staged prescaler code in bits 1:0, 3 staged modulus, 4 staged pulse width for pin A, 5 staged pulse width for pin B, 6 override (bit0 force A, bit1 force B, bit2 level for A, bit3 level for B).

Top module: `pwm_dbuf_chan`

## Requirements
- R1: While `gate_i` is low, reads of address 0 return zero, writes to address 0 are ignored, and the generator behaves as disabled. When the gate returns high, the bits stored before the gate fell are visible and in effect again.
- R2: A write of 1 to load-okay (address 0 bit1) takes effect only if the previous access to address 0 was a read that returned load-okay as 0 while the gate was high. Otherwise load-okay stays 0.
- R3: At a reload while load-okay is set and the gate is high, the staged prescaler code, modulus and both pulse widths become active. At no other time do the active values change.
- R4: Load-okay clears at the clock edge where that transfer takes place.
- R5: A write of 0 to load-okay before a reload cancels the pending transfer. The active values then stay unchanged at that reload.
- R6: After reset, every register reads zero, both pins are low and `irq_o` is low.
- R7: While the generator is disabled, the counter and prescaler are held at zero and each pin is low unless its override is set.
- R8: An override with its force bit set drives its pin to the level bit, whether or not the generator is enabled.
- R9: When the generator is enabled and not overridden, pin A is high while count < active width A, and pin B is high while count >= active width B.
- R10: The counter counts 0 to the active modulus and then wraps to zero, which is a reload. The period is (modulus+1) times the prescale divisor in clocks.
- R11: Each reload sets the reload flag. Writing 1 to status bit0 clears it, and a reload in the same cycle as that write keeps it set.
- R12: `irq_o` is high exactly when the reload flag and the gated reload interrupt enable are both set.
- R13: Prescaler code c divides the clock by 2^c (1, 2, 4 or 8), and a new code takes effect only through a reload transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Write gate for the control bits |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (marks a read for the load-okay handshake) |
| addr_i | input | 3 | Register address |
| wdata_i | input | CW | Write data |
| rdata_o | output | CW | Read data for `addr_i` (combinational) |
| pin_a_o | output | 1 | PWM pin A |
| pin_b_o | output | 1 | PWM pin B |
| irq_o | output | 1 | Reload interrupt request |

## Verification
The bench builds the block with CW = 8 and keeps random moduli at 15 or below, so a full period of at most 128 clocks fits many times into the run. With that setting, many reloads at every prescale code occur, together with widths of zero and widths above the modulus. The 8-bit data also brings cancelled transfers, gate drops mid-period and flag-clear collisions within reach of random stimulus.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int AW = 3;
  localparam int CODE_W = 2;
  localparam int PRE_W = (1 << CODE_W) - 1;

  typedef enum logic [AW-1:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_PRESC = 3'd2,
    A_MOD   = 3'd3,
    A_WIDA  = 3'd4,
    A_WIDB  = 3'd5,
    A_OVR   = 3'd6
  } reg_addr_e;

  localparam int B_EN   = 0;
  localparam int B_LDOK = 1;
  localparam int B_RLIE = 2;
endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   gate_i,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [CW-1:0]          wdata_i,
  input  logic                   reload_i,
  output logic [CW-1:0]          rdata_o,
  output logic                   en_o,
  output logic                   rlie_o,
  output logic                   ldok_o,
  output logic                   flag_o,
  output logic [3:0]             ovr_o,
  output logic [CODE_W-1:0]      act_code_o,
  output logic [CW-1:0]          act_mod_o,
  output logic [1:0][CW-1:0]     act_wid_o
);
  logic en_q, en_n, rlie_q, rlie_n, ldok_q, ldok_n, arm_q, arm_n, flag_q, flag_n;
  logic [3:0] ovr_q, ovr_n;
  logic [CODE_W-1:0] stg_code_q, stg_code_n, act_code_q, act_code_n;
  logic [CW-1:0] stg_mod_q, stg_mod_n, act_mod_q, act_mod_n;
  logic [1:0][CW-1:0] stg_wid_q, stg_wid_n, act_wid_q, act_wid_n;
  logic xfer;
  logic wr_ctrl;

  assign xfer    = reload_i & ldok_q & gate_i;
  assign wr_ctrl = wr_en_i & (addr_i == A_CTRL) & gate_i;

  always_comb begin
    en_n = en_q; rlie_n = rlie_q; ldok_n = ldok_q; arm_n = arm_q; flag_n = flag_q;
    ovr_n = ovr_q; stg_code_n = stg_code_q; stg_mod_n = stg_mod_q; stg_wid_n = stg_wid_q;
    act_code_n = act_code_q; act_mod_n = act_mod_q; act_wid_n = act_wid_q;
    if (xfer) begin
      act_code_n = stg_code_q;
      act_mod_n  = stg_mod_q;
      act_wid_n  = stg_wid_q;
      ldok_n     = 1'b0;
    end
    if (reload_i) flag_n = 1'b1;
    else if (wr_en_i && addr_i == A_STAT && wdata_i[0]) flag_n = 1'b0;
    if (rd_en_i && addr_i == A_CTRL && gate_i && !ldok_q) arm_n = 1'b1;
    if (wr_ctrl) begin
      en_n   = wdata_i[B_EN];
      rlie_n = wdata_i[B_RLIE];
      arm_n  = 1'b0;
      if (!wdata_i[B_LDOK]) ldok_n = 1'b0;
      else if (arm_q) ldok_n = 1'b1;
    end
    if (wr_en_i) begin
      case (addr_i)
        A_PRESC: stg_code_n   = wdata_i[CODE_W-1:0];
        A_MOD:   stg_mod_n    = wdata_i;
        A_WIDA:  stg_wid_n[0] = wdata_i;
        A_WIDB:  stg_wid_n[1] = wdata_i;
        A_OVR:   ovr_n        = wdata_i[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; rlie_q <= 1'b0; ldok_q <= 1'b0; arm_q <= 1'b0; flag_q <= 1'b0;
      ovr_q <= '0; stg_code_q <= '0; stg_mod_q <= '0; stg_wid_q <= '0;
      act_code_q <= '0; act_mod_q <= '0; act_wid_q <= '0;
    end else begin
      en_q <= en_n; rlie_q <= rlie_n; ldok_q <= ldok_n; arm_q <= arm_n; flag_q <= flag_n;
      ovr_q <= ovr_n; stg_code_q <= stg_code_n; stg_mod_q <= stg_mod_n; stg_wid_q <= stg_wid_n;
      act_code_q <= act_code_n; act_mod_q <= act_mod_n; act_wid_q <= act_wid_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[B_EN]   = en_q & gate_i;
        rdata_o[B_LDOK] = ldok_q & gate_i;
        rdata_o[B_RLIE] = rlie_q & gate_i;
      end
      A_STAT:  rdata_o[0] = flag_q;
      A_PRESC: rdata_o[CODE_W-1:0] = stg_code_q;
      A_MOD:   rdata_o = stg_mod_q;
      A_WIDA:  rdata_o = stg_wid_q[0];
      A_WIDB:  rdata_o = stg_wid_q[1];
      A_OVR:   rdata_o[3:0] = ovr_q;
      default: ;
    endcase
  end

  assign en_o       = en_q & gate_i;
  assign rlie_o     = rlie_q & gate_i;
  assign ldok_o     = ldok_q;
  assign flag_o     = flag_q;
  assign ovr_o      = ovr_q;
  assign act_code_o = act_code_q;
  assign act_mod_o  = act_mod_q;
  assign act_wid_o  = act_wid_q;
endmodule

// File: rtl/pwm_dbuf_timebase.sv
module pwm_dbuf_timebase
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CW-1:0]     mod_i,
  output logic [CW-1:0]     cnt_o,
  output logic              reload_o
);
  logic [PRE_W-1:0] pre_q, pre_n, pre_lim;
  logic [CW-1:0] cnt_q, cnt_n;
  logic tick;

  assign pre_lim  = PRE_W'((1 << code_i) - 1);
  assign tick     = en_i & (pre_q == pre_lim);
  assign reload_o = tick & (cnt_q == mod_i);

  always_comb begin
    pre_n = pre_q;
    cnt_n = cnt_q;
    if (!en_i) begin
      pre_n = '0;
      cnt_n = '0;
    end else if (tick) begin
      pre_n = '0;
      cnt_n = reload_o ? '0 : cnt_q + 1'b1;
    end else begin
      pre_n = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_n;
      cnt_q <= cnt_n;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_dbuf_outstage.sv
module pwm_dbuf_outstage #(
  parameter int CW = 16
) (
  input  logic                en_i,
  input  logic [CW-1:0]       cnt_i,
  input  logic [1:0][CW-1:0]  wid_i,
  input  logic [3:0]          ovr_i,
  output logic [1:0]          pin_o
);
  for (genvar g = 0; g < 2; g++) begin : g_pin
    logic below;
    logic raw;
    assign below = cnt_i < wid_i[g];
    if (g == 0) begin : g_true
      assign raw = below;
    end else begin : g_compl
      assign raw = ~below;
    end
    assign pin_o[g] = ovr_i[g] ? ovr_i[g+2] : (en_i & raw);
  end
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  output logic          pin_a_o,
  output logic          pin_b_o,
  output logic          irq_o
);
  logic [1:0] rst_sync_q;
  logic rst_n;
  logic en_eff, rlie_eff, ldok_q, flag, reload;
  logic [3:0] ovr;
  logic [CODE_W-1:0] act_code;
  logic [CW-1:0] act_mod, cnt;
  logic [1:0][CW-1:0] act_wid;
  logic [1:0] pins;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  pwm_dbuf_regs #(.CW(CW)) regs_i (
    .clk_i, .rst_ni(rst_n), .gate_i, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .reload_i(reload), .rdata_o, .en_o(en_eff), .rlie_o(rlie_eff), .ldok_o(ldok_q),
    .flag_o(flag), .ovr_o(ovr), .act_code_o(act_code), .act_mod_o(act_mod),
    .act_wid_o(act_wid)
  );

  pwm_dbuf_timebase #(.CW(CW)) tb_i (
    .clk_i, .rst_ni(rst_n), .en_i(en_eff), .code_i(act_code), .mod_i(act_mod),
    .cnt_o(cnt), .reload_o(reload)
  );

  pwm_dbuf_outstage #(.CW(CW)) out_i (
    .en_i(en_eff), .cnt_i(cnt), .wid_i(act_wid), .ovr_i(ovr), .pin_o(pins)
  );

  assign pin_a_o = pins[0];
  assign pin_b_o = pins[1];
  assign irq_o   = flag & rlie_eff;
endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          gate_i,
  input logic [2:0]    addr_i,
  input logic [CW-1:0] rdata_o,
  input logic          en_eff,
  input logic          ldok_q,
  input logic          reload,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] act_mod,
  input logic [1:0]    act_code,
  input logic          flag,
  input logic          pin_a_o,
  input logic [3:0]    ovr
);
  a_r4_ldok_autoclear: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reload && ldok_q && gate_i) |=> !ldok_q);
  a_r3_active_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !reload |=> ($stable(act_mod) && $stable(act_code)));
  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt <= act_mod);
  a_r11_flag_set: assert property (@(posedge clk_i) disable iff (!rst_n)
    reload |=> flag);
  a_r1_gate_read_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!gate_i && addr_i == 3'd0) |-> (rdata_o == '0));
  a_r7_cnt_stopped: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_eff |=> (cnt == '0));
  a_r7_pin_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!en_eff && !ovr[0]) |-> !pin_a_o);
endmodule

bind pwm_dbuf_chan pwm_dbuf_chk #(.CW(CW)) chk_i (
  .clk_i(clk_i), .rst_n(rst_n), .gate_i(gate_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .en_eff(en_eff), .ldok_q(ldok_q), .reload(reload), .cnt(cnt), .act_mod(act_mod),
  .act_code(act_code), .flag(flag), .pin_a_o(pin_a_o), .ovr(ovr)
);

// File: tb/pwm_dbuf_chan_tb.sv
module pwm_dbuf_chan_tb_top;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic gate = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic pin_a, pin_b, irq;

  always #5 clk = ~clk;

  pwm_dbuf_chan #(.CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .gate_i(gate), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_a_o(pin_a), .pin_b_o(pin_b),
    .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference state
  logic m_en, m_ldok, m_rlie, m_arm, m_flag;
  logic [3:0] m_ovr;
  logic [1:0] s_code, a_code;
  logic [CW-1:0] s_mod, a_mod, s_wa, a_wa, s_wb, a_wb;
  int unsigned m_pre, m_cnt;

  task automatic expect_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_pin(input int idx);
    logic en_e;
    en_e = m_en & gate;
    if (idx == 0) return m_ovr[0] ? m_ovr[2] : (en_e && m_cnt < a_wa);
    return m_ovr[1] ? m_ovr[3] : (en_e && !(m_cnt < a_wb));
  endfunction

  function automatic logic [CW-1:0] m_read(input logic [2:0] a);
    logic [CW-1:0] v;
    v = '0;
    case (a)
      3'd0: v[2:0] = {m_rlie & gate, m_ldok & gate, m_en & gate};
      3'd1: v[0] = m_flag;
      3'd2: v[1:0] = s_code;
      3'd3: v = s_mod;
      3'd4: v = s_wa;
      3'd5: v = s_wb;
      3'd6: v[3:0] = m_ovr;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string rtag(input logic [2:0] a);
    case (a)
      3'd0: return "R1 R2 R4";
      3'd1: return "R11";
      3'd6: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic m_reset();
    m_en = 0; m_ldok = 0; m_rlie = 0; m_arm = 0; m_flag = 0; m_ovr = '0;
    s_code = '0; a_code = '0; s_mod = '0; a_mod = '0;
    s_wa = '0; a_wa = '0; s_wb = '0; a_wb = '0; m_pre = 0; m_cnt = 0;
  endtask

  task automatic m_step();
    logic en_e, tick, rl, xf;
    logic n_ldok, n_arm;
    en_e = m_en & gate;
    tick = en_e && (m_pre == (32'd1 << a_code) - 1);
    rl   = tick && (m_cnt == a_mod);
    xf   = rl && m_ldok && gate;
    n_ldok = m_ldok; n_arm = m_arm;
    if (xf) begin
      a_code = s_code; a_mod = s_mod; a_wa = s_wa; a_wb = s_wb; n_ldok = 0;
    end
    if (!en_e) begin m_pre = 0; m_cnt = 0; end
    else if (tick) begin m_pre = 0; m_cnt = rl ? 0 : m_cnt + 1; end
    else m_pre = m_pre + 1;
    if (rl) m_flag = 1;
    else if (wr_en && addr == 3'd1 && wdata[0]) m_flag = 0;
    if (rd_en && addr == 3'd0 && gate && !m_ldok) n_arm = 1;
    if (wr_en) begin
      case (addr)
        3'd0: if (gate) begin
          m_en = wdata[0]; m_rlie = wdata[2]; n_arm = 0;
          if (!wdata[1]) n_ldok = 0;
          else if (m_arm) n_ldok = 1;
        end
        3'd2: s_code = wdata[1:0];
        3'd3: s_mod = wdata;
        3'd4: s_wa = wdata;
        3'd5: s_wb = wdata;
        3'd6: m_ovr = wdata[3:0];
        default: ;
      endcase
    end
    m_ldok = n_ldok; m_arm = n_arm;
  endtask

  // one clock: drive at the falling edge, compare after settling, advance model
  task automatic cyc(input logic w, input logic r, input logic [2:0] a, input logic [CW-1:0] d);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    expect_eq(rtag(a), int'(rdata), int'(m_read(a)));
    expect_eq("R7 R8 R9 R10 R13 pin A", int'(pin_a), int'(m_pin(0)));
    expect_eq("R7 R8 R9 R10 R13 pin B", int'(pin_b), int'(m_pin(1)));
    expect_eq("R12", int'(irq), int'(m_flag & m_rlie & gate));
    m_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, '0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    cyc(1, 0, a, d);
  endtask

  task automatic arm_load(input logic [CW-1:0] ctl);
    cyc(0, 1, 3'd0, '0);
    wr(3'd0, ctl);
  endtask

  int hi_a;

  initial begin
    void'($urandom(32'd2718));
    m_reset();
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    idle(3);

    // R6: everything zero after reset
    for (int a = 0; a < 7; a++) begin
      addr = 3'(a); #1;
      expect_eq("R6 reset readback", int'(rdata), 0);
    end
    expect_eq("R6 pin A", int'(pin_a), 0);
    expect_eq("R6 pin B", int'(pin_b), 0);
    expect_eq("R6 irq", int'(irq), 0);

    // stage period 4, widths 2
    wr(3'd3, 8'd3); wr(3'd4, 8'd2); wr(3'd5, 8'd2);
    // R2: write of 1 without a preceding read is dropped
    wr(3'd0, 8'b010);
    addr = 3'd0; #1;
    expect_eq("R2 unarmed ldok", int'(rdata[1]), 0);
    arm_load(8'b011);
    addr = 3'd0; #1;
    expect_eq("R2 armed ldok", int'(rdata[1]), 1);
    idle(3);
    addr = 3'd0; #1;
    expect_eq("R4 ldok autoclear", int'(rdata[1]), 0);
    hi_a = 0;
    for (int i = 0; i < 8; i++) begin
      #1; hi_a += int'(pin_a);
      expect_eq("R9 complement", int'(pin_b), int'(!pin_a));
      cyc(0, 0, 3'd0, '0);
    end
    expect_eq("R9 R10 duty over two periods", hi_a, 4);

    // R5: arm a change then cancel it
    wr(3'd3, 8'd7);
    arm_load(8'b011);
    wr(3'd0, 8'b001);
    idle(6);
    hi_a = 0;
    for (int i = 0; i < 8; i++) begin
      #1; hi_a += int'(pin_a);
      cyc(0, 0, 3'd0, '0);
    end
    expect_eq("R5 cancelled transfer keeps period", hi_a, 4);

    // R1: gate low masks and blocks control
    gate = 1'b0;
    wr(3'd0, 8'b000);
    addr = 3'd0; #1;
    expect_eq("R1 gated read", int'(rdata), 0);
    idle(2);
    expect_eq("R1 gated pins idle", int'(pin_a), 0);
    gate = 1'b1;
    addr = 3'd0; #1;
    expect_eq("R1 enable retained", int'(rdata[0]), 1);

    // R12: interrupt enable gates the flag
    wr(3'd0, 8'b101);
    idle(6);
    expect_eq("R12 irq with enable", int'(irq), 1);
    wr(3'd0, 8'b001);
    expect_eq("R12 irq masked", int'(irq), 0);

    // R7 R8: disabled with override
    wr(3'd0, 8'b000);
    wr(3'd6, 8'b0101);
    idle(2);
    expect_eq("R8 forced pin A", int'(pin_a), 1);
    expect_eq("R7 pin B idle", int'(pin_b), 0);
    wr(3'd6, 8'b0000);

    // R13 R3: new prescale via handshake, rest random
    wr(3'd2, 8'd2);
    arm_load(8'b001);
    for (int n = 0; n < 40000; n++) begin
      int unsigned r;
      r = $urandom % 100;
      if (!gate) begin
        if ($urandom % 10 == 0) gate = 1'b1;
      end else if ($urandom % 300 == 0) gate = 1'b0;
      if (r < 4)        wr(3'd0, CW'({($urandom % 2), ($urandom % 2), ($urandom % 10 != 0)}));
      else if (r < 8)   cyc(0, 1, 3'd0, '0);
      else if (r < 12)  arm_load(CW'({($urandom % 2), 2'b11}));
      else if (r < 14)  wr(3'd2, CW'($urandom % 4));
      else if (r < 16)  wr(3'd3, CW'($urandom % 16));
      else if (r < 18)  wr(3'(4 + $urandom % 2), CW'($urandom % 19));
      else if (r < 19)  wr(3'd6, ($urandom % 4 == 0) ? CW'($urandom % 16) : '0);
      else if (r < 21)  wr(3'd1, 8'd1);
      else if (r < 24)  cyc(0, 1, 3'($urandom % 7), '0);
      else              cyc(0, 0, 3'($urandom % 7), '0);
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #1900000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule